// File: doc/BRIEF.md
# HDLC Receive Deframer with Frame Status

This block sits behind a line framer. It takes a serial bit stream, one bit per cycle in which `bit_vld` is high, and finds the flag octets that bound HDLC frames. Between flags it removes the zeros the transmitter inserted, packs the remaining bits into bytes, and runs the 16-bit frame check sequence over them. Each byte is offered on a one-byte write port that feeds an external receive store. That store is not part of this block.

Every frame that is long enough ends with one extra status byte on the same port, marked by `wr_stat`. The status byte reports four things: a bad check sequence, an abort, an overrun of the downstream store, and a length that is not a whole number of bytes. The `fcs_pass` input selects how the two check-sequence bytes are handled. In normal mode they are withheld. In performance-report mode they are written as ordinary data. A separate `idle` output reports a long run of ones on the line.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: The pattern 0,1,1,1,1,1,1,0 is a flag. A flag opens a frame, and a flag inside a frame both closes it and opens the next one, so frames separated by a single shared flag are each delivered with their own status byte.
- R2: Inside a frame, a 0 that follows five consecutive 1s is removed before byte assembly, so a payload byte of 0xFF or 0x7E is delivered unchanged.
- R3: Bytes are assembled least significant bit first: the first bit received after zero removal becomes bit 0 of the written byte.
- R4: After the last data byte of a closed frame, one status byte is written with `wr_stat`=1. Its bits are: bit 7 bad check sequence, bit 6 abort, bit 5 overrun, bit 4 bad length. Bits 3..0 are zero. 0x00 means the frame is good. Data bytes carry `wr_stat`=0.
- R5: The check sequence is the 16-bit reflected CRC with polynomial x^16+x^12+x^5+1, preset to 0xFFFF, computed over all assembled bits. Status bit 7 is clear exactly when the register holds 0xF0B8 after the frame's last assembled bit.
- R6: With `fcs_pass`=0, the two most recent complete bytes of a frame are withheld and never written. With `fcs_pass`=1, every complete byte is written, including both check-sequence bytes (low byte first).
- R7: A seventh consecutive 1 inside a frame that has already assembled at least one bit is an abort. It writes a status byte with bit 6 set, bit 7 set if the CRC is not 0xF0B8, and bit 4 set if a partial byte is pending. The withheld bytes are dropped, and all bits up to the next flag are ignored.
- R8: A flag followed by seven 1s before any bit has been assembled writes nothing.
- R9: `idle` goes high after the 15th consecutive received 1 and low after any received 0.
- R10: A data byte that is due while `wr_full`=1 is dropped and sets status bit 5 of that frame. The status byte itself is written whatever the level of `wr_full`.
- R11: In normal mode, a frame whose assembled bit count is not a multiple of 8 sets status bit 4. Just before the status byte it writes the leftover bits as one byte, with the first leftover bit at bit 0 and the unused upper bits at zero.
- R12: A frame closed by a flag after fewer than 16 assembled bits writes nothing, not even a status byte.
- R13: While `rst` is high, and in the cycle after it is released, `wr_en` and `idle` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial line bit |
| fcs_pass | input | 1 | 1: write the check-sequence bytes as data; 0: withhold them |
| wr_full | input | 1 | Downstream store cannot accept a data byte |
| wr_en | output | 1 | Write strobe for `wr_data` |
| wr_data | output | 8 | Data or status byte |
| wr_stat | output | 1 | Marks the written byte as a frame status byte |
| idle | output | 1 | Long run of ones seen on the line |

## Verification
A wrong count of consecutive ones shows up at the very next flag or stuffed zero. Depending on which bit is wrong, it splits a byte, merges two frames, or raises a false abort, and the effect reaches the write port within one byte time. A misaligned bit lag or byte counter corrupts the first payload byte written after an opening flag, and also changes the bad-length bit of the next status byte. Faults in the CRC register or the withheld-byte pipeline stay hidden until the frame closes. Then they appear as a wrong bit 7, as missing or extra bytes, or as check-sequence bytes leaking out in normal mode. The bench therefore compares the full byte sequence of each frame, including the status byte.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam int BYTE_W     = 8;
  localparam int STUFF_ONES = 5;   // ones before a deleted zero
  localparam int FLAG_ONES  = 6;   // ones inside a flag
  localparam int LAG_BITS   = FLAG_ONES; // flag bits that enter the data path before it is recognised
  localparam int FCS_W      = 16;
  localparam int FCS_BYTES  = FCS_W / BYTE_W;
  localparam logic [FCS_W-1:0] FCS_PRESET   = 16'hFFFF;
  localparam logic [FCS_W-1:0] FCS_POLY_REV = 16'h8408;
  localparam logic [FCS_W-1:0] FCS_GOOD     = 16'hF0B8;
  // status byte bit positions
  localparam int ST_BADCRC = 7;
  localparam int ST_ABORT  = 6;
  localparam int ST_OVR    = 5;
  localparam int ST_BADLEN = 4;
endpackage

// File: rtl/hdlc_line_decoder.sv
module hdlc_line_decoder
  import hdlc_rx_pkg::*;
#(
  parameter int IDLE_RUN = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_vld,
  input  logic bit_in,
  output logic ev_data,
  output logic ev_flag,
  output logic ev_abort,
  output logic idle_o
);
  localparam int OW = $clog2(IDLE_RUN + 1);

  logic [OW-1:0] ones_q;
  logic          idle_q;

  // classify the current bit against the run of ones before it
  always_comb begin
    ev_data  = bit_vld && (ones_q < OW'(STUFF_ONES));
    ev_flag  = bit_vld && !bit_in && (ones_q == OW'(FLAG_ONES));
    ev_abort = bit_vld &&  bit_in && (ones_q == OW'(FLAG_ONES));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ones_q <= '0;
      idle_q <= 1'b0;
    end else if (bit_vld) begin
      if (!bit_in) begin
        ones_q <= '0;
      end else if (ones_q != OW'(IDLE_RUN)) begin
        ones_q <= ones_q + OW'(1);
      end
      idle_q <= bit_in && (ones_q >= OW'(IDLE_RUN - 1));
    end
  end

  assign idle_o = idle_q;

  assert_idle_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (bit_vld && !bit_in) |=> !idle_o);

  assert_idle_rise_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(idle_o) |-> $past(bit_vld && bit_in));
endmodule

// File: rtl/hdlc_bit_lag.sv
module hdlc_bit_lag #(
  parameter int LAG = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic push,
  input  logic bit_in,
  output logic out_vld,
  output logic out_bit
);
  localparam int CW = $clog2(LAG + 1);

  logic [LAG-1:0] sr_q;
  logic [CW-1:0]  cnt_q;

  // a bit leaves only once it is older than any flag that could still follow it
  assign out_vld = push && (cnt_q == CW'(LAG));
  assign out_bit = sr_q[LAG-1];

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (push) begin
      sr_q <= {sr_q[LAG-2:0], bit_in};
      if (cnt_q != CW'(LAG)) cnt_q <= cnt_q + CW'(1);
    end
  end

  assert_lag_empty_after_clear_R1: assert property (@(posedge clk) disable iff (rst)
    clear |=> !out_vld);
endmodule

// File: rtl/hdlc_fcs16.sv
module hdlc_fcs16
  import hdlc_rx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic init,
  input  logic upd,
  input  logic bit_in,
  output logic crc_ok
);
  logic [FCS_W-1:0] crc_q, crc_n;

  always_comb begin
    crc_n = {1'b0, crc_q[FCS_W-1:1]};
    if (crc_q[0] ^ bit_in) crc_n = crc_n ^ FCS_POLY_REV;
  end

  always_ff @(posedge clk) begin
    if (rst || init) crc_q <= FCS_PRESET;
    else if (upd)    crc_q <= crc_n;
  end

  assign crc_ok = (crc_q == FCS_GOOD);
endmodule

// File: rtl/hdlc_frame_builder.sv
module hdlc_frame_builder
  import hdlc_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             asm_vld,
  input  logic             asm_bit,
  input  logic             ev_flag,
  input  logic             ev_abort,
  input  logic             crc_ok,
  input  logic             fcs_pass,
  input  logic             wr_full,
  output logic             open_o,
  output logic             wr_en_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic             wr_stat_o
);
  localparam int CW = $clog2(BYTE_W);
  localparam int SW = CW + 1;
  localparam int NW = $clog2(FCS_BYTES + 1);

  logic              open_q, anyb_q, ovr_q, spend_q;
  logic [BYTE_W-1:0] sh_q, stat_q;
  logic [CW-1:0]     bcnt_q;
  logic [NW-1:0]     nby_q;
  logic [BYTE_W-1:0] hold_q [FCS_BYTES];
  logic              wr_en_q, wr_st_q;
  logic [BYTE_W-1:0] wr_dat_q;

  logic [BYTE_W-1:0] sh_n, part_byte, dw_dat;
  logic              byte_done, part, close_ok, end_abort, full_len;
  logic              dw_req, dw_go, dw_drop, ovr_eff;

  function automatic logic [BYTE_W-1:0] mk_stat(input logic bad, input logic ab,
                                                input logic ov, input logic bl);
    logic [BYTE_W-1:0] s;
    s            = '0;
    s[ST_BADCRC] = bad;
    s[ST_ABORT]  = ab;
    s[ST_OVR]    = ov;
    s[ST_BADLEN] = bl;
    return s;
  endfunction

  always_comb begin
    sh_n      = {asm_bit, sh_q[BYTE_W-1:1]};
    byte_done = asm_vld && (bcnt_q == CW'(BYTE_W - 1));
    part      = (bcnt_q != '0);
    part_byte = sh_q >> (SW'(BYTE_W) - {1'b0, bcnt_q});
    full_len  = (nby_q == NW'(FCS_BYTES));
    close_ok  = ev_flag && open_q && full_len;
    end_abort = ev_abort && open_q && anyb_q;
    dw_req    = 1'b0;
    dw_dat    = '0;
    if (byte_done) begin
      if (fcs_pass) begin
        dw_req = 1'b1;
        dw_dat = sh_n;
      end else if (full_len) begin
        dw_req = 1'b1;
        dw_dat = hold_q[0];
      end
    end else if (close_ok && part && !fcs_pass) begin
      dw_req = 1'b1;
      dw_dat = part_byte;
    end else if (close_ok && part) begin
      dw_req = 1'b1;
      dw_dat = part_byte;
    end
    dw_go   = dw_req && !wr_full;
    dw_drop = dw_req &&  wr_full;
    ovr_eff = ovr_q || dw_drop;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q   <= 1'b0;
      anyb_q   <= 1'b0;
      ovr_q    <= 1'b0;
      spend_q  <= 1'b0;
      stat_q   <= '0;
      sh_q     <= '0;
      bcnt_q   <= '0;
      nby_q    <= '0;
      for (int i = 0; i < FCS_BYTES; i++) hold_q[i] <= '0;
      wr_en_q  <= 1'b0;
      wr_st_q  <= 1'b0;
      wr_dat_q <= '0;
    end else begin
      wr_en_q <= 1'b0;
      wr_st_q <= 1'b0;
      if (spend_q) begin
        wr_en_q  <= 1'b1;
        wr_st_q  <= 1'b1;
        wr_dat_q <= stat_q;
        spend_q  <= 1'b0;
      end else if (dw_go) begin
        wr_en_q  <= 1'b1;
        wr_dat_q <= dw_dat;
      end
      if (dw_drop) ovr_q <= 1'b1;

      if (asm_vld) begin
        anyb_q <= 1'b1;
        sh_q   <= sh_n;
        bcnt_q <= bcnt_q + CW'(1);
        if (byte_done) begin
          for (int i = 0; i < FCS_BYTES - 1; i++) hold_q[i] <= hold_q[i+1];
          hold_q[FCS_BYTES-1] <= sh_n;
          if (!full_len) nby_q <= nby_q + NW'(1);
        end
      end

      if (ev_flag || ev_abort) begin
        if (close_ok) begin
          stat_q  <= mk_stat(!crc_ok, 1'b0, ovr_eff, part);
          spend_q <= 1'b1;
        end
        if (end_abort) begin
          stat_q  <= mk_stat(!crc_ok, 1'b1, ovr_q, part);
          spend_q <= 1'b1;
        end
        open_q <= ev_flag;
        anyb_q <= 1'b0;
        ovr_q  <= 1'b0;
        sh_q   <= '0;
        bcnt_q <= '0;
        nby_q  <= '0;
      end
    end
  end

  assign open_o    = open_q;
  assign wr_en_o   = wr_en_q;
  assign wr_data_o = wr_dat_q;
  assign wr_stat_o = wr_st_q;

  assert_stat_low_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && wr_stat_o) |-> (wr_data_o[3:0] == 4'h0));

  assert_no_collision_R4: assert property (@(posedge clk) disable iff (rst)
    spend_q |-> !dw_req);

  assert_status_follows_flag_R4: assert property (@(posedge clk) disable iff (rst)
    wr_stat_o |-> $past(ev_flag || ev_abort, 2));

  assert_no_write_when_full_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && !wr_stat_o) |-> !$past(wr_full));
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int IDLE_RUN = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_vld,
  input  logic       bit_in,
  input  logic       fcs_pass,
  input  logic       wr_full,
  output logic       wr_en,
  output logic [7:0] wr_data,
  output logic       wr_stat,
  output logic       idle
);
  logic ev_data, ev_flag, ev_abort;
  logic open_s, asm_vld, asm_bit, crc_ok;

  hdlc_line_decoder #(.IDLE_RUN(IDLE_RUN)) u_line (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in),
    .ev_data(ev_data), .ev_flag(ev_flag), .ev_abort(ev_abort), .idle_o(idle)
  );

  hdlc_bit_lag #(.LAG(LAG_BITS)) u_lag (
    .clk(clk), .rst(rst), .clear(ev_flag || ev_abort),
    .push(ev_data && open_s), .bit_in(bit_in),
    .out_vld(asm_vld), .out_bit(asm_bit)
  );

  hdlc_fcs16 u_fcs (
    .clk(clk), .rst(rst), .init(ev_flag || ev_abort),
    .upd(asm_vld), .bit_in(asm_bit), .crc_ok(crc_ok)
  );

  hdlc_frame_builder u_build (
    .clk(clk), .rst(rst), .asm_vld(asm_vld), .asm_bit(asm_bit),
    .ev_flag(ev_flag), .ev_abort(ev_abort), .crc_ok(crc_ok),
    .fcs_pass(fcs_pass), .wr_full(wr_full), .open_o(open_s),
    .wr_en_o(wr_en), .wr_data_o(wr_data), .wr_stat_o(wr_stat)
  );
endmodule

// File: tb/tb_hdlc_rx_deframer.sv
`timescale 1ns/1ps
module tb_hdlc_rx_deframer;
  logic clk = 1'b0, rst = 1'b1;
  logic bit_vld = 1'b0, bit_in = 1'b0, fcs_pass = 1'b0, wr_full = 1'b0;
  logic wr_en, wr_stat, idle;
  logic [7:0] wr_data;

  int checks = 0, errors = 0;
  int log_n = 0;
  logic [7:0] log_d [0:63];
  logic       log_s [0:63];
  logic       dbits [0:255];
  int dcnt = 0, tx_ones = 0;
  logic [15:0] last_fcs;

  // {pass, bad_fcs, len, payload (byte0 lowest), expected status}
  localparam int NV = 6;
  localparam logic [44:0] VEC [NV] = '{
    {1'b0, 1'b0, 3'd3, 32'h000F3CA5, 8'h00},
    {1'b0, 1'b0, 3'd2, 32'h0000FFFF, 8'h00},
    {1'b0, 1'b1, 3'd4, 32'h81007E7E, 8'h80},
    {1'b1, 1'b0, 3'd2, 32'h00003412, 8'h00},
    {1'b0, 1'b0, 3'd1, 32'h0000007E, 8'h00},
    {1'b1, 1'b1, 3'd3, 32'h00C31FF8, 8'h80}
  };

  hdlc_rx_deframer dut (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in),
    .fcs_pass(fcs_pass), .wr_full(wr_full), .wr_en(wr_en),
    .wr_data(wr_data), .wr_stat(wr_stat), .idle(idle)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (!rst && wr_en) begin
      if (log_n < 64) begin
        log_d[log_n] = wr_data;
        log_s[log_n] = wr_stat;
      end
      log_n++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    logic [15:0] n;
    n = {1'b0, c[15:1]};
    if (c[0] ^ b) n = n ^ 16'h8408;
    return n;
  endfunction

  function automatic logic [15:0] crc_bits(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++) c = crc_step(c, dbits[i]);
    return c;
  endfunction

  task automatic send_raw(input logic b);
    bit_vld = 1'b1;
    bit_in  = b;
    @(negedge clk);
  endtask

  task automatic gap(input int n);
    bit_vld = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_data_bit(input logic b);
    send_raw(b);
    dbits[dcnt] = b;
    dcnt++;
    if (b) begin
      tx_ones++;
      if (tx_ones == 5) begin
        send_raw(1'b0);
        tx_ones = 0;
      end
    end else tx_ones = 0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_data_bit(v[i]);
  endtask

  task automatic send_flag();
    send_raw(1'b0);
    for (int i = 0; i < 6; i++) send_raw(1'b1);
    send_raw(1'b0);
    tx_ones = 0;
  endtask

  task automatic send_frame(input int len, input logic [31:0] pay, input logic bad);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < len; i++) begin
      for (int k = 0; k < 8; k++) c = crc_step(c, pay[8*i+k]);
      send_byte(pay[8*i +: 8]);
    end
    last_fcs = ~c ^ {15'd0, bad};
    send_byte(last_fcs[7:0]);
    send_byte(last_fcs[15:8]);
    send_flag();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int base;
    logic [15:0] c;
    repeat (3) @(negedge clk);
    chk("R13 wr_en in reset", wr_en, 0);
    chk("R13 idle in reset", idle, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R13 wr_en after reset", wr_en, 0);
    chk("R13 idle after reset", idle, 0);

    send_flag();
    // R1: frames below share one flag between them
    for (int v = 0; v < NV; v++) begin
      logic [44:0] e;
      int len, exp_n;
      e = VEC[v];
      len = int'(e[42:40]);
      fcs_pass = e[44];
      base = log_n;
      dcnt = 0;
      send_frame(len, e[39:8], e[43]);
      gap(4);
      exp_n = len + (e[44] ? 2 : 0) + 1;
      chk("R1 R6 write count", log_n - base, exp_n);
      for (int i = 0; i < len; i++) begin
        chk("R2 R3 payload byte", log_d[base+i], e[8+8*i +: 8]);
        chk("R4 data not status", log_s[base+i], 0);
      end
      if (e[44]) begin
        chk("R6 fcs low passed", log_d[base+len], last_fcs[7:0]);
        chk("R6 fcs high passed", log_d[base+len+1], last_fcs[15:8]);
      end
      chk("R4 R5 status byte", log_d[base+exp_n-1], e[7:0]);
      chk("R4 status marker", log_s[base+exp_n-1], 1);
    end
    fcs_pass = 1'b0;

    // R12: too short, nothing written
    base = log_n;
    dcnt = 0;
    send_byte(8'h5A);
    send_flag();
    gap(4);
    chk("R12 short frame silent", log_n - base, 0);

    // R11: three trailing bits 1,0,1 after the check sequence
    base = log_n;
    dcnt = 0;
    send_byte(8'hC3);
    send_byte(8'h96);
    c = 16'hFFFF;
    for (int i = 0; i < 16; i++) c = crc_step(c, dbits[i]);
    c = ~c;
    send_byte(c[7:0]);
    send_byte(c[15:8]);
    send_data_bit(1'b1);
    send_data_bit(1'b0);
    send_data_bit(1'b1);
    send_flag();
    gap(4);
    chk("R11 write count", log_n - base, 4);
    chk("R11 payload0", log_d[base], 8'hC3);
    chk("R11 payload1", log_d[base+1], 8'h96);
    chk("R11 partial byte", log_d[base+2], 8'h05);
    chk("R11 status", log_d[base+3], {(crc_bits(dcnt) != 16'hF0B8), 3'b001, 4'h0});

    // R10: store full for a whole frame
    base = log_n;
    dcnt = 0;
    wr_full = 1'b1;
    send_frame(3, 32'h00030201, 1'b0);
    gap(4);
    wr_full = 1'b0;
    chk("R10 only status written", log_n - base, 1);
    chk("R10 overrun status", log_d[base], 8'h20);
    chk("R10 status marker", log_s[base], 1);

    // R7: abort after four bytes
    base = log_n;
    dcnt = 0;
    send_byte(8'h11);
    send_byte(8'h22);
    send_byte(8'h33);
    send_byte(8'h44);
    for (int i = 0; i < 7; i++) send_raw(1'b1);
    gap(4);
    chk("R7 write count", log_n - base, 2);
    chk("R7 released byte", log_d[base], 8'h11);
    chk("R7 abort status", log_d[base+1], {(crc_bits(31) != 16'hF0B8), 3'b101, 4'h0});
    send_byte(8'h24);
    send_byte(8'h42);
    gap(4);
    chk("R7 ignored until flag", log_n - base, 2);
    send_flag();

    // R8 then R9: flag followed by ones
    base = log_n;
    for (int i = 0; i < 7; i++) send_raw(1'b1);
    gap(4);
    chk("R8 no abort report", log_n - base, 0);
    for (int i = 0; i < 7; i++) send_raw(1'b1);
    chk("R9 idle after 14 ones", idle, 0);
    send_raw(1'b1);
    chk("R9 idle after 15 ones", idle, 1);
    send_raw(1'b0);
    chk("R9 idle cleared by zero", idle, 0);
    send_flag();
    base = log_n;
    dcnt = 0;
    send_frame(2, 32'h0000BEEF, 1'b0);
    gap(4);
    chk("R8 recovery count", log_n - base, 3);
    chk("R8 recovery byte", log_d[base], 8'hEF);
    chk("R8 recovery status", log_d[base+2], 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule